// File: doc/BRIEF.md
# Print engine video serializer

This block carries a rendered page bitmap out of memory and feeds it to a laser print engine as a one-bit serial video stream. Software loads a small staging register set with the address of the image, its width in words, its height in lines, a top margin in lines and a left margin in video clocks. The write of the height register commits the whole set and arms the block. Writes to the other registers only stage values.

Once armed, the block raises a print request and reads image words from a simple request/valid memory port into a small prefetch buffer. When the buffer is full, or the whole image has already been read, it waits for a rising edge on the engine's frame sync. That edge drops the print request, sets a sticky band-begin flag and starts the page. Each rising edge of line sync then opens a scan line. The block skips the top margin lines. On each of the remaining lines it drives zero for the left margin and then shifts the image words out one bit per rising edge of the video clock, most significant bit first. After the last pixel of the last line it sets a sticky page-end flag, which tells software that the image memory can be reused.

Frame sync, line sync and the video clock are sampled in the system clock domain. An edge takes effect at the first system clock edge at which the new level is seen.

Top module: `video_serializer`

## Requirements
- R1: After reset, video, print_req, mem_req, irq_band, irq_page and err_underrun are all 0.
- R2: Writes to selector 0 (image base address), 1 (width in 16-bit words), 2 (top margin in lines) and 3 (left margin in video clocks) start nothing: mem_req and print_req stay 0. A write to selector 4 (height in lines) while idle commits all staged values and arms the block. print_req is 1 by the second clock edge after that write.
- R3: While armed, reads go out to consecutive word addresses starting at the committed base, and mem_addr stays stable while mem_req waits for mem_rvalid. A frame sync rising edge is ignored until the prefetch buffer is full or every image word has been read.
- R4: A frame sync rising edge that is accepted sets irq_band and clears print_req at the same clock edge.
- R5: After the page starts, the first top-margin line sync rising edges open no line, and video stays 0 on them.
- R6: On each image line, the first left-margin video clock edges drive video to 0. The next 16 × width edges drive the line's words in address order, bit 15 first. Outside a line, a video clock edge drives video to 0, and video changes only on a video clock edge, a line sync edge or a page start.
- R7: The video clock edge that carries the last pixel of line number height sets irq_page. The block then returns to idle with print_req at 0, and the next video clock edge drives video to 0.
- R8: When a word is needed for output and the prefetch buffer is empty, err_underrun is set and stays set.
- R9: Flags are sticky and are cleared by writing selector 5 with 1 in bit 0 (band-begin), bit 1 (page-end) or bit 2 (underrun). Bits written 0 leave their flag unchanged. A flag being set in the same cycle as its clear stays set.
- R10: A selector 4 write while a page is in progress does not re-arm the block. Staged writes during a page do not change the page being sent.
- R11: Exactly width × height reads complete per page. The prefetch buffer never holds more than its depth, and no read is requested once the page has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector (0 base, 1 width, 2 top, 3 left, 4 height/arm, 5 flag clear) |
| cfg_wdata | input | DATA_W (24) | Register write data |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | ADDR_W (24) | Word address of the pending read |
| mem_rvalid | input | 1 | Read data valid, completes the pending read |
| mem_rdata | input | WORD_W (16) | Read data |
| print_req | output | 1 | Page print request to the engine |
| fsync | input | 1 | Engine frame sync, top of page |
| lsync | input | 1 | Engine line sync, left edge of a line |
| vclk | input | 1 | Engine video clock |
| video | output | 1 | Serial video pixel |
| irq_band | output | 1 | Sticky band-begin flag |
| irq_page | output | 1 | Sticky page-end flag |
| err_underrun | output | 1 | Sticky prefetch underrun flag |

## Verification
The hardest state to reach from the ports is an underrun. Read latency has to exceed the time the engine takes to drain a word while the buffer still looks healthy at page start, so random short latencies never hit it. A directed page therefore sets the bench memory latency to about 80 cycles, waits for the slow prefetch to fill, and then clocks a four-word line at two system cycles per pixel. The third word is then needed well before it can arrive. A second hard case is a frame sync that arrives while the buffer is still filling: the bench forces it with a long-latency page and pulses frame sync right after arming.

// File: rtl/svp_pkg.sv
package svp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_FILL,
      SEQ_WAIT,
      SEQ_RUN
   } seq_e;

   localparam logic [2:0] SEL_BASE   = 3'd0;
   localparam logic [2:0] SEL_WIDTH  = 3'd1;
   localparam logic [2:0] SEL_TOP    = 3'd2;
   localparam logic [2:0] SEL_LEFT   = 3'd3;
   localparam logic [2:0] SEL_HEIGHT = 3'd4;
   localparam logic [2:0] SEL_CLEAR  = 3'd5;

   localparam int FLAG_BAND = 0;
   localparam int FLAG_PAGE = 1;
   localparam int FLAG_URUN = 2;
endpackage

// File: rtl/svp_regs.sv
module svp_regs
   import svp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DIM_W  = 12,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              set_band,
   input  logic              set_page,
   input  logic              set_urun,
   output logic [ADDR_W-1:0] base,
   output logic [DIM_W-1:0]  width,
   output logic [DIM_W-1:0]  top,
   output logic [DIM_W-1:0]  left,
   output logic [DIM_W-1:0]  height,
   output logic              arm,
   output logic              irq_band,
   output logic              irq_page,
   output logic              err_urun
);
   logic [ADDR_W-1:0] st_base;
   logic [DIM_W-1:0]  st_width, st_top, st_left;
   logic [2:0]        clr;

   assign clr = (wr && sel == SEL_CLEAR) ? wdata[2:0] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_base  <= '0;
         st_width <= '0;
         st_top   <= '0;
         st_left  <= '0;
         base     <= '0;
         width    <= '0;
         top      <= '0;
         left     <= '0;
         height   <= '0;
         arm      <= 1'b0;
      end else begin
         arm <= 1'b0;
         if (wr) begin
            case (sel)
               SEL_BASE:  st_base  <= wdata[ADDR_W-1:0];
               SEL_WIDTH: st_width <= wdata[DIM_W-1:0];
               SEL_TOP:   st_top   <= wdata[DIM_W-1:0];
               SEL_LEFT:  st_left  <= wdata[DIM_W-1:0];
               SEL_HEIGHT: begin
                  if (!busy) begin
                     base   <= st_base;
                     width  <= st_width;
                     top    <= st_top;
                     left   <= st_left;
                     height <= wdata[DIM_W-1:0];
                     arm    <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_band <= 1'b0;
         irq_page <= 1'b0;
         err_urun <= 1'b0;
      end else begin
         irq_band <= set_band | (irq_band & ~clr[FLAG_BAND]);
         irq_page <= set_page | (irq_page & ~clr[FLAG_PAGE]);
         err_urun <= set_urun | (err_urun & ~clr[FLAG_URUN]);
      end
   end

   // R9: a set flag survives any cycle without a matching clear bit
   a_r9_band_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_band && !clr[FLAG_BAND]) |=> irq_band);
   a_r8_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_urun && !clr[FLAG_URUN]) |=> err_urun);
endmodule

// File: rtl/svp_prefetch.sv
module svp_prefetch #(
   parameter int ADDR_W = 24,
   parameter int WORD_W = 16,
   parameter int DEPTH  = 2,
   parameter int TOT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [ADDR_W-1:0] base,
   input  logic [TOT_W-1:0]  total,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              pop,
   output logic [WORD_W-1:0] pop_data,
   output logic              empty,
   output logic              ready
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("svp_prefetch: DEPTH must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt;
   logic [TOT_W-1:0]  left_words;
   logic              push, pop_ok;

   assign mem_req = run && (left_words != '0) && (cnt < CNT_W'(DEPTH));
   assign push    = mem_req && mem_rvalid;
   assign empty   = (cnt == '0);
   assign pop_ok  = pop && !empty;
   assign ready   = (cnt == CNT_W'(DEPTH)) || (left_words == '0);
   assign pop_data = empty ? '0 : slot[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot[i] <= '0;
            else if (push && wr_ptr == PTR_W'(i)) slot[i] <= mem_rdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         cnt        <= '0;
         mem_addr   <= '0;
         left_words <= '0;
      end else if (start) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         cnt        <= '0;
         mem_addr   <= base;
         left_words <= total;
      end else begin
         if (push) begin
            wr_ptr     <= bump(wr_ptr);
            mem_addr   <= mem_addr + ADDR_W'(1);
            left_words <= left_words - TOT_W'(1);
         end
         if (pop_ok) rd_ptr <= bump(rd_ptr);
         if (push && !pop_ok)      cnt <= cnt + CNT_W'(1);
         else if (!push && pop_ok) cnt <= cnt - CNT_W'(1);
      end
   end

   // R11: occupancy bounded by depth
   a_r11_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R3: a pending read holds its address until answered
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid && run) |=> (!run || (mem_req && $stable(mem_addr))));
endmodule

// File: rtl/svp_raster.sv
module svp_raster #(
   parameter int WORD_W = 16,
   parameter int DIM_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [DIM_W-1:0]  top,
   input  logic [DIM_W-1:0]  left,
   input  logic [DIM_W-1:0]  width,
   input  logic [DIM_W-1:0]  height,
   input  logic              lsync,
   input  logic              vclk,
   output logic              pop,
   input  logic [WORD_W-1:0] pop_data,
   input  logic              pop_empty,
   output logic              video,
   output logic              page_done,
   output logic              underrun
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int POS_W = DIM_W + BIT_W + 1;

   logic [1:0]        sync_q;
   logic              lsync_e, vclk_e;
   logic [POS_W-1:0]  pos, line_last;
   logic [BIT_W-1:0]  bitcnt;
   logic [WORD_W-1:0] shreg;
   logic              in_line, in_pix, line_end;
   logic [DIM_W-1:0]  top_seen, lines;

   generate
      for (genvar s = 0; s < 2; s++) begin : g_edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= (s == 0) ? lsync : vclk;
         end
      end
   endgenerate

   assign lsync_e   = lsync & ~sync_q[0];
   assign vclk_e    = vclk & ~sync_q[1];
   assign line_last = POS_W'(left) + (POS_W'(width) << BIT_W) - POS_W'(1);
   assign in_pix    = pos >= POS_W'(left);
   assign pop       = vclk_e && in_line && in_pix && (bitcnt == '0);
   assign underrun  = pop && pop_empty;
   assign line_end  = vclk_e && in_line && (pos == line_last);
   assign page_done = line_end && (lines == height - DIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         bitcnt   <= '0;
         shreg    <= '0;
         in_line  <= 1'b0;
         top_seen <= '0;
         lines    <= '0;
         video    <= 1'b0;
      end else if (start) begin
         pos      <= '0;
         bitcnt   <= '0;
         in_line  <= 1'b0;
         top_seen <= '0;
         lines    <= '0;
         video    <= 1'b0;
      end else if (run && lsync_e && !in_line) begin
         if (top_seen < top) begin
            top_seen <= top_seen + DIM_W'(1);
         end else begin
            in_line <= 1'b1;
            pos     <= '0;
            bitcnt  <= '0;
         end
         video <= 1'b0;
      end else if (vclk_e && in_line) begin
         if (!in_pix) begin
            video <= 1'b0;
         end else if (bitcnt == '0) begin
            video  <= pop_data[WORD_W-1];
            shreg  <= pop_data << 1;
            bitcnt <= BIT_W'(WORD_W - 1);
         end else begin
            video  <= shreg[WORD_W-1];
            shreg  <= shreg << 1;
            bitcnt <= bitcnt - BIT_W'(1);
         end
         pos <= pos + POS_W'(1);
         if (line_end) begin
            in_line <= 1'b0;
            lines   <= lines + DIM_W'(1);
         end
      end else if (vclk_e) begin
         video <= 1'b0;
      end
   end

   // R6: video moves only on a video clock edge, a line sync edge or page start
   a_r6_video_on_vclk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vclk_e && !lsync_e && !start) |=> $stable(video));
   // R5: margin lines never open a line
   a_r5_top_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (run && lsync_e && !in_line && top_seen < top && !start) |=> !in_line);
endmodule

// File: rtl/video_serializer.sv
module video_serializer
   import svp_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DIM_W      = 12,
   parameter int WORD_W     = 16,
   parameter int FIFO_DEPTH = 2,
   parameter int DATA_W     = (ADDR_W > DIM_W) ? ADDR_W : DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              print_req,
   input  logic              fsync,
   input  logic              lsync,
   input  logic              vclk,
   output logic              video,
   output logic              irq_band,
   output logic              irq_page,
   output logic              err_underrun
);
   localparam int TOT_W = 2 * DIM_W;

   generate
      if (ADDR_W > 32 || DIM_W > 16 || DIM_W < 2) begin : g_bad_dims
         $error("video_serializer: ADDR_W up to 32, DIM_W in 2..16");
      end
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("video_serializer: WORD_W must be a power of two");
      end
   endgenerate

   seq_e              state;
   logic [ADDR_W-1:0] c_base;
   logic [DIM_W-1:0]  c_width, c_top, c_left, c_height;
   logic              arm, busy, fsync_q, fsync_e, band_set;
   logic              pop, empty, ready, page_done, urun;
   logic [WORD_W-1:0] pop_data;
   logic [TOT_W-1:0]  total;

   assign busy      = (state != SEQ_IDLE) || arm;
   assign fsync_e   = fsync & ~fsync_q;
   assign band_set  = (state == SEQ_WAIT) && fsync_e;
   assign print_req = (state == SEQ_FILL) || (state == SEQ_WAIT);
   assign total     = TOT_W'(c_width) * TOT_W'(c_height);

   svp_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
      .busy(busy), .set_band(band_set), .set_page(page_done), .set_urun(urun),
      .base(c_base), .width(c_width), .top(c_top), .left(c_left), .height(c_height),
      .arm(arm), .irq_band(irq_band), .irq_page(irq_page), .err_urun(err_underrun)
   );

   svp_prefetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .TOT_W(TOT_W)) u_pf (
      .clk(clk), .rst_n(rst_n), .start(arm), .run(state != SEQ_IDLE),
      .base(c_base), .total(total), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pop(pop), .pop_data(pop_data),
      .empty(empty), .ready(ready)
   );

   svp_raster #(.WORD_W(WORD_W), .DIM_W(DIM_W)) u_ras (
      .clk(clk), .rst_n(rst_n), .start(band_set), .run(state == SEQ_RUN),
      .top(c_top), .left(c_left), .width(c_width), .height(c_height),
      .lsync(lsync), .vclk(vclk), .pop(pop), .pop_data(pop_data), .pop_empty(empty),
      .video(video), .page_done(page_done), .underrun(urun)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         fsync_q <= 1'b0;
      end else begin
         fsync_q <= fsync;
         case (state)
            SEQ_IDLE: if (arm)       state <= SEQ_FILL;
            SEQ_FILL: if (ready)     state <= SEQ_WAIT;
            SEQ_WAIT: if (fsync_e)   state <= SEQ_RUN;
            SEQ_RUN:  if (page_done) state <= SEQ_IDLE;
            default:                 state <= SEQ_IDLE;
         endcase
      end
   end

   // R4: accepted frame sync drops the request and flags band begin
   a_r4_print_drop: assert property (@(posedge clk) disable iff (!rst_n)
      band_set |=> (!print_req && irq_band));
   // R7: page end returns to idle
   a_r7_page_idle: assert property (@(posedge clk) disable iff (!rst_n)
      page_done |=> (state == SEQ_IDLE && irq_page));
   // R11: no reads once idle
   a_r11_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE) |-> !mem_req);
endmodule

// File: tb/sim_video_serializer.sv
module sim_video_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [23:0] cfg_wdata = '0;
   logic        mem_req;
   logic [23:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        print_req;
   logic        fsync = 1'b0, lsync = 1'b0, vclk = 1'b0;
   logic        video, irq_band, irq_page, err_underrun;

   int vectors = 0, fails = 0, rv_count = 0, mem_lat = 0, lat_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   video_serializer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .print_req(print_req), .fsync(fsync), .lsync(lsync), .vclk(vclk), .video(video),
      .irq_band(irq_band), .irq_page(irq_page), .err_underrun(err_underrun)
   );

   function automatic logic [15:0] img(input logic [23:0] a);
      logic [31:0] t;
      t = {8'h0, a} * 32'h9E3779B1;
      return t[31:16] ^ t[15:0];
   endfunction

   always @(negedge clk) begin
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
         if (lat_cnt >= mem_lat) begin
            mem_rvalid = 1'b1;
            mem_rdata  = img(mem_addr);
            rv_count++;
            lat_cnt = 0;
         end else lat_cnt++;
      end else lat_cnt = 0;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] s, input logic [23:0] d);
      @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic vtick();
      @(negedge clk); vclk = 1'b1;
      @(negedge clk); vclk = 1'b0;
   endtask

   task automatic lpulse();
      @(negedge clk); lsync = 1'b1;
      @(negedge clk); lsync = 1'b0;
   endtask

   task automatic fpulse();
      @(negedge clk); fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
   endtask

   task automatic program_page(input int base, w, top, left, h);
      cfg_write(3'd5, 24'h7);
      rv_count = 0;
      cfg_write(3'd0, 24'(base));
      cfg_write(3'd1, 24'(w));
      cfg_write(3'd2, 24'(top));
      cfg_write(3'd3, 24'(left));
      cfg_write(3'd4, 24'(h));
   endtask

   task automatic page_body(input int base, w, top, left, h, input bit chk_px, input bit poke);
      bit bad;
      logic [15:0] wd;
      logic exp_b, got_b;
      chk(print_req == 1'b1, "R2 print_req armed", print_req, 1);
      fpulse();
      chk(irq_band == 1'b1, "R4 band flag on frame sync", irq_band, 1);
      chk(print_req == 1'b0, "R4 print_req drops", print_req, 0);
      for (int t = 0; t < top; t++) begin
         lpulse();
         bad = 0;
         for (int k = 0; k < left + 3; k++) begin
            vtick();
            if (video !== 1'b0) bad = 1;
         end
         chk(!bad, "R5 top margin line dark", bad, 0);
      end
      for (int l = 0; l < h; l++) begin
         lpulse();
         bad = 0; exp_b = 0; got_b = 0;
         for (int k = 0; k < left + 16 * w; k++) begin
            logic e;
            vtick();
            if (k < left) e = 1'b0;
            else begin
               wd = img(24'(base + l * w + (k - left) / 16));
               e  = wd[15 - ((k - left) % 16)];
            end
            if (video !== e && !bad) begin bad = 1; exp_b = e; got_b = video; end
         end
         if (chk_px) chk(!bad, "R6 line pixels", got_b, exp_b);
         if (l == 0 && h > 1) chk(irq_page == 1'b0, "R7 no page end early", irq_page, 0);
         if (l == 0 && poke) begin
            cfg_write(3'd0, 24'h00ABC0);
            cfg_write(3'd4, 24'd5);
         end
      end
      chk(irq_page == 1'b1, "R7 page end flag", irq_page, 1);
      chk(print_req == 1'b0, "R7 R10 idle, not re-armed", print_req, 0);
      vtick();
      chk(video == 1'b0, "R7 video dark after page", video, 0);
      chk(mem_req == 1'b0, "R11 no read after page", mem_req, 0);
      if (chk_px) chk(rv_count == w * h, "R11 read count", rv_count, w * h);
   endtask

   task automatic full_page(input int base, w, top, left, h);
      program_page(base, w, top, left, h);
      repeat (24) @(negedge clk);
      page_body(base, w, top, left, h, 1, 0);
      chk(err_underrun == 1'b0, "R8 no underrun at short latency", err_underrun, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk({video, print_req, mem_req, irq_band, irq_page, err_underrun} == 6'b0,
          "R1 reset outputs", {video, print_req, mem_req, irq_band, irq_page, err_underrun}, 0);
      // R2: staging writes do nothing
      cfg_write(3'd0, 24'h000040);
      cfg_write(3'd1, 24'd2);
      cfg_write(3'd2, 24'd0);
      cfg_write(3'd3, 24'd1);
      repeat (8) @(negedge clk);
      chk(mem_req == 1'b0 && print_req == 1'b0, "R2 staged writes inert", {mem_req, print_req}, 0);

      // R3: slow prefetch, early frame sync ignored
      mem_lat = 30;
      program_page(24'h000100, 2, 1, 3, 2);
      @(negedge clk);
      chk(mem_req == 1'b1 && mem_addr == 24'h000100, "R3 first read at base", mem_addr, 24'h100);
      fpulse();
      chk(irq_band == 1'b0, "R3 early frame sync ignored", irq_band, 0);
      chk(print_req == 1'b1, "R3 still requesting", print_req, 1);
      repeat (100) @(negedge clk);
      page_body(24'h000100, 2, 1, 3, 2, 1, 0);

      // R9: selective clear leaves other flag
      cfg_write(3'd5, 24'h2);
      @(negedge clk);
      chk(irq_page == 1'b0 && irq_band == 1'b1, "R9 clear page only", {irq_band, irq_page}, 2'b10);
      cfg_write(3'd5, 24'h1);
      @(negedge clk);
      chk(irq_band == 1'b0, "R9 clear band", irq_band, 0);

      // corner: one word, no margins
      mem_lat = 0;
      full_page(24'h000FF0, 1, 0, 0, 1);

      // R10: writes during page
      mem_lat = 1;
      program_page(24'h002000, 2, 0, 2, 3);
      repeat (24) @(negedge clk);
      page_body(24'h002000, 2, 0, 2, 3, 1, 1);

      // random pages
      for (int it = 0; it < 6; it++) begin
         int b, w, t, lm, h;
         b  = int'($urandom & 32'h00FFFFFF);
         w  = 1 + int'($urandom % 3);
         t  = int'($urandom % 3);
         lm = int'($urandom % 6);
         h  = 1 + int'($urandom % 3);
         mem_lat = int'($urandom % 4);
         full_page(b, w, t, lm, h);
      end

      // R8: underrun with very slow memory
      mem_lat = 80;
      program_page(24'h003000, 4, 0, 0, 1);
      repeat (250) @(negedge clk);
      chk(err_underrun == 1'b0, "R8 no underrun before page", err_underrun, 0);
      page_body(24'h003000, 4, 0, 0, 1, 0, 0);
      chk(err_underrun == 1'b1, "R8 underrun flagged", err_underrun, 1);
      repeat (5) @(negedge clk);
      chk(err_underrun == 1'b1, "R8 underrun sticky", err_underrun, 1);
      cfg_write(3'd5, 24'h4);
      @(negedge clk);
      chk(err_underrun == 1'b0, "R9 clear underrun", err_underrun, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule